// File: doc/BRIEF.md
# Interleaved Half-Rate Shift Register

This block is a serial-in, serial-out delay line of `DEPTH` bits whose storage is split into `WAYS` banks. Each bank is `DEPTH/WAYS` bits long. On any one clock only one bank shifts. A rotating pointer picks the bank, so every flip-flop toggles at most once every `WAYS` cycles while the serial stream still moves one bit per cycle. A clock enable on the single system clock stands in for a divided clock, and no second clock domain exists.

The input bit is offered to all banks, and only the enabled bank captures it. This acts as the input demultiplexer. An output multiplexer driven by the same pointer reads the oldest bit of the bank that is about to shift, which rebuilds the serial stream at full rate. From the ports, the block cannot be told apart from a plain `DEPTH`-stage shift register. It is meant for long scan-like or test delay chains where switching activity matters more than a few extra multiplexer gates.

Top module: `interleaved_shift_reg`

## Requirements
- R1: `sdout` after clock edge m equals the `sdin` value sampled at edge m-(DEPTH-1), exactly as a plain DEPTH-stage register chain whose last stage drives the output.
- R2: A synchronous active-high `rst` clears every bank bit and returns the rotation pointer to bank 0, so `sdout` is 0 after a reset edge.
- R3: Exactly one bank is enabled per cycle. The enable rotates 0,1,...,WAYS-1,0,... one step per clock. A bank that is not enabled keeps its contents.
- R4: The bit sampled at the k-th edge after reset is captured by bank k mod WAYS, in that bank's first stage.
- R5: The output multiplexer selects the last stage of the bank enabled in the current cycle.
- R6: After a reset in the middle of a stream, `sdout` stays 0 for DEPTH-1 edges and then carries the new data with no trace of bits sent before the reset.
- R7: For WAYS of 1, 2 and 4 with the same DEPTH (default 16), the serial output sequence is identical for the same input sequence.
- R8: DEPTH must be a multiple of WAYS. Each bank then holds DEPTH/WAYS bits (8 bits for the default DEPTH=16, WAYS=2).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single system clock; all banks use it with a clock enable |
| rst | input | 1 | Synchronous active-high reset |
| sdin | input | 1 | Serial data in, sampled each rising edge |
| sdout | output | 1 | Serial data out, delayed copy of `sdin` |

## Verification
The assertions check on every cycle the properties local to the pieces of the block:
- the pointer steps and wraps;
- exactly one enable is active;
- idle banks hold their contents, and an enabled bank captures the input;
- reset clears every bank;
- the output multiplexer follows the live bank.

Only the bench scenarios can show that these pieces together form an exact DEPTH-stage delay. The bench compares the block against a plain register-chain model, with instances of one, two and four banks. It also measures single-pulse latency at every pointer phase and the flush after a mid-stream reset.

// File: rtl/ivsr_pkg.sv
package ivsr_pkg;

    // Width of a pointer able to name WAYS banks (never below 1 bit).
    function automatic int unsigned sel_width(input int unsigned ways);
        return (ways > 1) ? $clog2(ways) : 1;
    endfunction

    // Length of one bank in a DEPTH-bit line split into WAYS banks.
    function automatic int unsigned bank_len(input int unsigned depth,
                                             input int unsigned ways);
        return depth / ways;
    endfunction

    // True when the split is legal (R8).
    function automatic bit split_ok(input int unsigned depth,
                                    input int unsigned ways);
        return (ways != 0) && (depth % ways == 0) && (depth >= ways);
    endfunction

endpackage

// File: rtl/ivsr_sequencer.sv
module ivsr_sequencer #(
    parameter int unsigned WAYS  = 2,
    parameter int unsigned PTR_W = 1
) (
    input  logic             clk,
    input  logic             rst,
    output logic [PTR_W-1:0] ptr_o,
    output logic [WAYS-1:0]  en_o
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(WAYS - 1);

    // Rotation pointer: names the bank that shifts this cycle.
    always_ff @(posedge clk) begin
        if (rst)
            ptr_o <= '0;
        else if (ptr_o == LAST)
            ptr_o <= '0;
        else
            ptr_o <= ptr_o + 1'b1;
    end

    // Clock-enable decode, one line per bank.
    always_comb begin
        for (int i = 0; i < WAYS; i++)
            en_o[i] = (ptr_o == PTR_W'(i));
    end

    // R3: pointer advances by one per cycle
    a_r3_ptr_step: assert property (@(posedge clk) disable iff (rst)
        (ptr_o != LAST) |=> (ptr_o == $past(ptr_o) + 1'b1));
    // R3: pointer wraps after the last bank
    a_r3_ptr_wrap: assert property (@(posedge clk) disable iff (rst)
        (ptr_o == LAST) |=> (ptr_o == '0));
    // R3: one enable at a time
    a_r3_one_enable: assert property (@(posedge clk) disable iff (rst)
        $countones(en_o) == 1);
    // R2: reset homes the pointer
    a_r2_ptr_home: assert property (@(posedge clk)
        rst |=> (ptr_o == '0));

endmodule

// File: rtl/ivsr_bank.sv
module ivsr_bank #(
    parameter int unsigned LEN = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic din,
    output logic tail
);
    logic [LEN-1:0] bits;

    generate
        if (LEN == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst)     bits <= '0;
                else if (en) bits <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst)     bits <= '0;
                else if (en) bits <= {bits[LEN-2:0], din};
            end
        end
    endgenerate

    assign tail = bits[LEN-1];

    // R3: an idle bank keeps its contents
    a_r3_bank_hold: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(bits));
    // R4: an enabled bank captures the input in its first stage
    a_r4_bank_capture: assert property (@(posedge clk) disable iff (rst)
        en |=> (bits[0] == $past(din)));
    // R2: reset clears the bank
    a_r2_bank_clear: assert property (@(posedge clk)
        rst |=> (bits == '0));

endmodule

// File: rtl/ivsr_outmux.sv
module ivsr_outmux #(
    parameter int unsigned WAYS  = 2,
    parameter int unsigned PTR_W = 1
) (
    input  logic [WAYS-1:0]  tails,
    input  logic [PTR_W-1:0] sel,
    output logic             y
);
    always_comb begin
        y = 1'b0;
        for (int i = 0; i < WAYS; i++)
            if (sel == PTR_W'(i))
                y = tails[i];
    end
endmodule

// File: rtl/interleaved_shift_reg.sv
module interleaved_shift_reg #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned WAYS  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sdin,
    output logic sdout
);
    import ivsr_pkg::*;

    localparam int unsigned BANK_LEN = bank_len(DEPTH, WAYS);
    localparam int unsigned PTR_W    = sel_width(WAYS);
    localparam bit          LEGAL    = split_ok(DEPTH, WAYS);

    logic [PTR_W-1:0] ptr;
    logic [WAYS-1:0]  bank_en;
    logic [WAYS-1:0]  tails;

    ivsr_sequencer #(.WAYS(WAYS), .PTR_W(PTR_W)) u_seq (
        .clk   (clk),
        .rst   (rst),
        .ptr_o (ptr),
        .en_o  (bank_en)
    );

    // Input demux: every bank sees sdin, only the enabled one captures it.
    generate
        for (genvar b = 0; b < WAYS; b++) begin : g_bank
            ivsr_bank #(.LEN(BANK_LEN)) u_bank (
                .clk  (clk),
                .rst  (rst),
                .en   (bank_en[b]),
                .din  (sdin),
                .tail (tails[b])
            );
        end
    endgenerate

    ivsr_outmux #(.WAYS(WAYS), .PTR_W(PTR_W)) u_mux (
        .tails (tails),
        .sel   (ptr),
        .y     (sdout)
    );

    // R8: split must be legal
    initial a_r8_legal_split: assert (LEGAL);

    // R5: output comes from the bank enabled this cycle
    a_r5_out_live_bank: assert property (@(posedge clk) disable iff (rst)
        sdout == |(tails & bank_en));
    // R2: output low right after a reset edge
    a_r2_out_cleared: assert property (@(posedge clk)
        rst |=> !sdout);

endmodule

// File: tb/test_interleaved_shift_reg.sv
`timescale 1ns/1ps
module test_interleaved_shift_reg;
    localparam int N = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sdin = 1'b0;
    logic out_w2, out_w1, out_w4;
    logic [N-1:0] model;
    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;   // 250 MHz

    interleaved_shift_reg #(.DEPTH(N), .WAYS(2)) i_interleaved_shift_reg (
        .clk(clk), .rst(rst), .sdin(sdin), .sdout(out_w2));
    interleaved_shift_reg #(.DEPTH(N), .WAYS(1)) i_interleaved_shift_reg_w1 (
        .clk(clk), .rst(rst), .sdin(sdin), .sdout(out_w1));
    interleaved_shift_reg #(.DEPTH(N), .WAYS(4)) i_interleaved_shift_reg_w4 (
        .clk(clk), .rst(rst), .sdin(sdin), .sdout(out_w4));

    // Reference: plain N-stage chain, last stage is the output (R1).
    function automatic logic [N-1:0] ref_next(input logic [N-1:0] m,
                                              input logic r, input logic b);
        return r ? '0 : {m[N-2:0], b};
    endfunction

    // One clock: drive at negedge, update model at the edge, check at negedge.
    task automatic step(input logic b, input logic r, input string tag);
        sdin = b;
        rst  = r;
        @(posedge clk);
        model = ref_next(model, r, b);
        @(negedge clk);
        checks++;
        if (out_w2 !== model[N-1] || out_w1 !== model[N-1] || out_w4 !== model[N-1]) begin
            failures++;
            $display("FAIL %s: ways2=%b ways1=%b ways4=%b expected=%b",
                     tag, out_w2, out_w1, out_w4, model[N-1]);
        end
    endtask

    // Pulse latency: after a pulse, count edges until each output rises.
    task automatic pulse_latency(input int phase, input string tag);
        int lat = -1;
        for (int i = 0; i < N; i++) step(1'b0, 1'b0, tag);
        for (int i = 0; i < phase; i++) step(1'b0, 1'b0, tag);
        step(1'b1, 1'b0, tag);
        for (int i = 1; i <= N + 2; i++) begin
            step(1'b0, 1'b0, tag);
            if (lat < 0 && out_w2 && out_w1 && out_w4) lat = i;
        end
        checks++;
        if (lat != N - 1) begin
            failures++;
            $display("FAIL %s: pulse latency actual=%0d expected=%0d (phase %0d)",
                     tag, lat, N - 1, phase);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not complete actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20120713));
        model = '0;
        @(negedge clk);
        // R2: reset state
        step(1'b1, 1'b1, "R2 reset");
        step(1'b1, 1'b1, "R2 reset held");

        // R1 / R7: random stream across all bank counts
        for (int i = 0; i < 300; i++)
            step(1'($urandom_range(0, 1)), 1'b0, "R1 R7 random");

        // R1: long runs of ones then zeros
        for (int i = 0; i < 2 * N; i++) step(1'b1, 1'b0, "R1 ones burst");
        for (int i = 0; i < 2 * N; i++) step(1'b0, 1'b0, "R1 zeros burst");

        // R5: alternating and period-3 patterns stress the output rotation
        for (int i = 0; i < 3 * N; i++) step(1'(i % 2), 1'b0, "R5 alternating");
        for (int i = 0; i < 3 * N; i++) step(1'(i % 3 == 0), 1'b0, "R5 period3");

        // R3 / R4: single pulse entering at every pointer phase
        for (int p = 0; p < 4; p++) pulse_latency(p, "R3 R4 pulse phase");

        // R6: reset in mid stream, then flush and new data
        for (int i = 0; i < N + 3; i++) step(1'b1, 1'b0, "R6 prefill");
        step(1'b0, 1'b1, "R6 mid reset");
        for (int i = 0; i < N - 1; i++) step(1'b0, 1'b0, "R6 flush zero");
        for (int i = 0; i < 2 * N; i++)
            step(1'($urandom_range(0, 1)), 1'b0, "R6 new data");

        // R8: default split gives 8-bit banks; delay still N for ways 2
        for (int i = 0; i < 100; i++)
            step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 40) == 0), "R8 R1 random reset mix");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule